// File: doc/BRIEF.md
# MSI Mask and Pending Controller

This block turns application interrupt requests into message-signaled interrupt writes for a small group of PCIe functions. Each function has its own configuration state: a legacy-interrupt disable flag, an MSI enable, a 3-bit vector-count code, a 64-bit message address, a 32-bit message data word, and a mask bit and a pending bit for each vector. Software reaches this state through a simple register write/read port.

The application raises an interrupt by giving a function and a vector on a request/acknowledge interface. If the vector is open, the block queues a message write. If the vector is masked, the block records it as pending and returns a separate status code. When software later clears that mask bit, the deferred message goes out. The application can instead drop the pending interrupt, and then no message is sent for it.

Queued messages leave through a valid/ready output that carries address and data. TLP framing is left to the logic downstream.

Top module: `msi_pend_ctrl`

## Requirements
- R1: After reset, `app_ack` and `msg_valid` are 0, and every register of every function reads 0. The mask register is included.
- R2: Register selects on `cfg_sel`:
  - 0: control word. Bit 0 is MSI enable, bits 3:1 are the vector-count code, and bit 8 is legacy interrupt disable.
  - 1: address low word.
  - 2: address high word.
  - 3: message data.
  - 4: vector mask, with bit v belonging to vector v.
  - 5: pending bits (read-only).

  Writes land on the function named by `cfg_func`, and `cfg_rdata` returns the selected register of that function in the same cycle.
- R3: A request on an enabled function, for an in-range and unmasked vector, is acknowledged with status 2'b00. Exactly one message then appears carrying that function's 64-bit address.
- R4: A vector-count code n allows 2^n vectors, and codes 6 and 7 behave as 5. The message data is the programmed data word with its low n bits replaced by the vector number.
- R5: A request is rejected with status 2'b10 in two cases: the function's MSI enable is 0, or the vector is not below 2^n. A rejected request sends no message and sets no pending bit.
- R6: A request on a masked vector is acknowledged with status 2'b01. It sends no message and sets that vector's pending bit, which reads back as 1. Writes to the pending register change nothing.
- R7: When software clears the mask bit of a pending vector, that vector's message is sent and its pending bit reads 0.
- R8: A request with `app_drop` high is acknowledged with status 2'b11 and clears the vector's pending bit. A later unmask then sends no message.
- R9: When several deferred or queued messages wait together, they leave in ascending order: by function index first, then by vector number.
- R10: An unmask write and a request for the same vector can arrive in the same cycle. In that case the request is judged against the new mask, is acknowledged with status 2'b00, and combines with the deferred message into a single message. The pending bit reads 0 afterwards.
- R11: `app_ack` is high for exactly one cycle, in the cycle after the request is sampled. A request held high is not sampled again in its acknowledge cycle, so a held request is acknowledged every second cycle.
- R12: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_func | input | FUNC_W | Function selected for register access |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational |
| app_req | input | 1 | Interrupt request, held until acknowledged |
| app_drop | input | 1 | With the request: drop the pending interrupt |
| app_func | input | FUNC_W | Function of the request |
| app_vec | input | VEC_LOG2 | Vector of the request |
| app_ack | output | 1 | One-cycle acknowledge |
| app_status | output | 2 | Outcome, valid with `app_ack` |
| msg_valid | output | 1 | Message write available |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_addr | output | ADDR_W | Message address |
| msg_data | output | 32 | Message data |

## Verification
Request timing:
- The acknowledge and status of a request are due in the cycle after the edge that samples the request.
- The resulting message becomes valid one cycle later and transfers on the following edge.

Register timing:
- Register reads are combinational, so a pending bit changed at a write edge can be read in the very next cycle.
- A message released by an unmask is valid one cycle after the write edge.

Sampling method:
- The bench drives inputs on falling edges and samples outputs shortly after a falling edge.
- It waits a fixed number of whole cycles that covers each of these latencies.
- A monitor records every completed message, so message counts and their order are compared after the fact.

// File: rtl/msi_pkg.sv
package msi_pkg;

   localparam int REG_W = 32;

   typedef enum logic [1:0] {
      ST_SENT    = 2'b00,
      ST_PENDING = 2'b01,
      ST_REJECT  = 2'b10,
      ST_DROPPED = 2'b11
   } msi_status_e;

   typedef enum logic [2:0] {
      SEL_CTRL    = 3'd0,
      SEL_ADDR_LO = 3'd1,
      SEL_ADDR_HI = 3'd2,
      SEL_DATA    = 3'd3,
      SEL_MASK    = 3'd4,
      SEL_PEND    = 3'd5
   } cfg_sel_e;

   localparam int CTRL_EN_BIT     = 0;
   localparam int CTRL_CODE_LSB   = 1;
   localparam int CTRL_LEGACY_BIT = 8;

endpackage

// File: rtl/msi_func_regs.sv
module msi_func_regs
   import msi_pkg::*;
#(
   parameter  int VEC_LOG2 = 5,
   parameter  int ADDR_W   = 64,
   localparam int NVEC     = 1 << VEC_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        sel,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   input  logic              ev_valid,
   input  logic              ev_drop,
   input  logic [VEC_LOG2-1:0] ev_vec,
   output msi_status_e       ev_status,
   input  logic [NVEC-1:0]   grant,
   output logic [NVEC-1:0]   issue,
   output logic [NVEC-1:0]   mask_o,
   output logic [NVEC-1:0]   pend_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [REG_W-1:0]  data_o,
   output logic [2:0]        code_o
);

   localparam logic [2:0] CODE_MAX = 3'(VEC_LOG2);
   localparam int         HI_W     = ADDR_W - REG_W;

   logic              en_q, legacy_q;
   logic [2:0]        code_q;
   logic [ADDR_W-1:0] addr_q;
   logic [REG_W-1:0]  data_q;
   logic [NVEC-1:0]   mask_q, pend_q, issue_q;

   logic [NVEC-1:0]   mask_next, released, vec_bit, pend_next, issue_next;
   logic [VEC_LOG2:0] span;
   logic              in_range;

   // vector-count code clamped to what the vector width supports
   assign code_o   = (code_q > CODE_MAX) ? CODE_MAX : code_q;
   assign span     = {{VEC_LOG2{1'b0}}, 1'b1} << code_o;
   assign in_range = {1'b0, ev_vec} < span;
   assign vec_bit  = {{(NVEC-1){1'b0}}, 1'b1} << ev_vec;

   // look-ahead mask: a write in this cycle already governs this cycle's request
   assign mask_next = (wr_en && sel == SEL_MASK) ? wr_data[NVEC-1:0] : mask_q;
   assign released  = pend_q & ~mask_next;

   always_comb begin
      if (ev_drop)                      ev_status = ST_DROPPED;
      else if (!en_q || !in_range)      ev_status = ST_REJECT;
      else if ((mask_next & vec_bit) != '0) ev_status = ST_PENDING;
      else                              ev_status = ST_SENT;
   end

   always_comb begin
      pend_next  = pend_q & mask_next;
      issue_next = (issue_q & ~grant) | released;
      if (ev_valid) begin
         case (ev_status)
            ST_PENDING: pend_next  = pend_next | vec_bit;
            ST_SENT:    issue_next = issue_next | vec_bit;
            ST_DROPPED: pend_next  = pend_next & ~vec_bit;
            default:    ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         legacy_q <= 1'b0;
         code_q   <= '0;
         data_q   <= '0;
         mask_q   <= '0;
         pend_q   <= '0;
         issue_q  <= '0;
      end else begin
         mask_q  <= mask_next;
         pend_q  <= pend_next;
         issue_q <= issue_next;
         if (wr_en) begin
            case (sel)
               SEL_CTRL: begin
                  en_q     <= wr_data[CTRL_EN_BIT];
                  code_q   <= wr_data[CTRL_CODE_LSB +: 3];
                  legacy_q <= wr_data[CTRL_LEGACY_BIT];
               end
               SEL_DATA: data_q <= wr_data;
               default:  ;
            endcase
         end
      end
   end

   // address register: low word always full width, high word sized by ADDR_W
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (wr_en && sel == SEL_ADDR_LO) begin
         addr_q[REG_W-1:0] <= wr_data;
      end else if (wr_en && sel == SEL_ADDR_HI) begin
         addr_q[ADDR_W-1:REG_W] <= wr_data[HI_W-1:0];
      end
   end

   always_comb begin
      case (sel)
         SEL_CTRL:    rd_data = {23'd0, legacy_q, 4'd0, code_q, en_q};
         SEL_ADDR_LO: rd_data = addr_q[REG_W-1:0];
         SEL_ADDR_HI: rd_data = REG_W'(addr_q[ADDR_W-1:REG_W]);
         SEL_DATA:    rd_data = data_q;
         SEL_MASK:    rd_data = REG_W'(mask_q);
         SEL_PEND:    rd_data = REG_W'(pend_q);
         default:     rd_data = '0;
      endcase
   end

   assign issue  = issue_q;
   assign mask_o = mask_q;
   assign pend_o = pend_q;
   assign addr_o = addr_q;
   assign data_o = data_q;

endmodule

// File: rtl/msi_pick_lowest.sv
module msi_pick_lowest #(
   parameter  int W     = 128,
   localparam int IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/msi_msg_out.sv
module msi_msg_out
   import msi_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int VEC_LOG2 = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [ADDR_W-1:0]   addr_in,
   input  logic [REG_W-1:0]    base_data,
   input  logic [2:0]          code,
   input  logic [VEC_LOG2-1:0] vec,
   output logic                can_load,
   output logic                msg_valid,
   input  logic                msg_ready,
   output logic [ADDR_W-1:0]   msg_addr,
   output logic [REG_W-1:0]    msg_data
);

   logic [REG_W-1:0] low_mask, merged;

   assign low_mask = ~({REG_W{1'b1}} << code);
   assign merged   = (base_data & ~low_mask) | (REG_W'(vec) & low_mask);
   assign can_load = !msg_valid || msg_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
      end else if (load) begin
         msg_valid <= 1'b1;
         msg_addr  <= addr_in;
         msg_data  <= merged;
      end else if (msg_ready) begin
         msg_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/msi_pend_ctrl.sv
module msi_pend_ctrl
   import msi_pkg::*;
#(
   parameter  int NUM_FUNC = 4,
   parameter  int VEC_LOG2 = 5,
   parameter  int ADDR_W   = 64,
   localparam int FUNC_W   = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr,
   input  logic [FUNC_W-1:0]   cfg_func,
   input  logic [2:0]          cfg_sel,
   input  logic [REG_W-1:0]    cfg_wdata,
   output logic [REG_W-1:0]    cfg_rdata,
   input  logic                app_req,
   input  logic                app_drop,
   input  logic [FUNC_W-1:0]   app_func,
   input  logic [VEC_LOG2-1:0] app_vec,
   output logic                app_ack,
   output logic [1:0]          app_status,
   output logic                msg_valid,
   input  logic                msg_ready,
   output logic [ADDR_W-1:0]   msg_addr,
   output logic [REG_W-1:0]    msg_data
);

   localparam int NVEC   = 1 << VEC_LOG2;
   localparam int FLAT_W = NUM_FUNC * NVEC;
   localparam int IDX_W  = $clog2(FLAT_W);

   // elaboration-time parameter checks
   if (NUM_FUNC < 1) begin : g_bad_func
      $error("NUM_FUNC must be at least 1");
   end
   if (VEC_LOG2 < 1 || VEC_LOG2 > 5) begin : g_bad_vec
      $error("VEC_LOG2 must be 1..5");
   end
   if (ADDR_W <= REG_W || ADDR_W > 2 * REG_W) begin : g_bad_addr
      $error("ADDR_W must be 33..64");
   end

   logic                accept, ack_q, func_ok;
   msi_status_e         status_q, status_sel;
   msi_status_e         st_arr   [NUM_FUNC];
   logic [REG_W-1:0]    rd_arr   [NUM_FUNC];
   logic [ADDR_W-1:0]   addr_arr [NUM_FUNC];
   logic [REG_W-1:0]    data_arr [NUM_FUNC];
   logic [2:0]          code_arr [NUM_FUNC];
   logic [FLAT_W-1:0]   issue_flat, mask_flat, pend_flat;

   logic                pick_found, can_load, load;
   logic [IDX_W-1:0]    pick_idx;
   logic [FUNC_W-1:0]   g_func;
   logic [VEC_LOG2-1:0] g_vec;

   // one request in flight: none is sampled during its acknowledge cycle
   assign accept  = app_req && !ack_q;
   assign func_ok = int'(app_func) < NUM_FUNC;

   assign g_func = FUNC_W'(pick_idx >> VEC_LOG2);
   assign g_vec  = pick_idx[VEC_LOG2-1:0];
   assign load   = pick_found && can_load;

   for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func_regs
      logic [NVEC-1:0] grant_f;
      assign grant_f = (load && int'(g_func) == f) ?
                       ({{(NVEC-1){1'b0}}, 1'b1} << g_vec) : '0;

      msi_func_regs #(
         .VEC_LOG2 (VEC_LOG2),
         .ADDR_W   (ADDR_W)
      ) u_regs (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (cfg_wr && int'(cfg_func) == f),
         .sel       (cfg_sel),
         .wr_data   (cfg_wdata),
         .rd_data   (rd_arr[f]),
         .ev_valid  (accept && int'(app_func) == f),
         .ev_drop   (app_drop),
         .ev_vec    (app_vec),
         .ev_status (st_arr[f]),
         .grant     (grant_f),
         .issue     (issue_flat[f*NVEC +: NVEC]),
         .mask_o    (mask_flat[f*NVEC +: NVEC]),
         .pend_o    (pend_flat[f*NVEC +: NVEC]),
         .addr_o    (addr_arr[f]),
         .data_o    (data_arr[f]),
         .code_o    (code_arr[f])
      );
   end

   assign status_sel = func_ok ? st_arr[app_func] : ST_REJECT;
   assign cfg_rdata  = (int'(cfg_func) < NUM_FUNC) ? rd_arr[cfg_func] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q    <= 1'b0;
         status_q <= ST_SENT;
      end else begin
         ack_q    <= accept;
         status_q <= status_sel;
      end
   end

   assign app_ack    = ack_q;
   assign app_status = status_q;

   msi_pick_lowest #(
      .W (FLAT_W)
   ) u_pick (
      .req   (issue_flat),
      .found (pick_found),
      .idx   (pick_idx)
   );

   msi_msg_out #(
      .ADDR_W   (ADDR_W),
      .VEC_LOG2 (VEC_LOG2)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .addr_in   (addr_arr[g_func]),
      .base_data (data_arr[g_func]),
      .code      (code_arr[g_func]),
      .vec       (g_vec),
      .can_load  (can_load),
      .msg_valid (msg_valid),
      .msg_ready (msg_ready),
      .msg_addr  (msg_addr),
      .msg_data  (msg_data)
   );

endmodule

// File: rtl/msi_pend_ctrl_chk.sv
module msi_pend_ctrl_chk #(
   parameter  int NUM_FUNC = 4,
   parameter  int VEC_LOG2 = 5,
   parameter  int ADDR_W   = 64,
   localparam int FLAT_W   = NUM_FUNC * (1 << VEC_LOG2)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              app_req,
   input logic              app_ack,
   input logic [1:0]        app_status,
   input logic              msg_valid,
   input logic              msg_ready,
   input logic [ADDR_W-1:0] msg_addr,
   input logic [31:0]       msg_data,
   input logic [FLAT_W-1:0] mask_flat,
   input logic [FLAT_W-1:0] pend_flat
);

   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      app_ack |=> !app_ack); // R11

   AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      app_ack |-> $past(app_req)); // R11

   AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R12

   AST_PEND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_flat & ~mask_flat) == '0); // R6

   AST_REJECT_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (app_ack && app_status == 2'b10) |-> ((pend_flat & ~$past(pend_flat)) == '0)); // R5

endmodule

bind msi_pend_ctrl msi_pend_ctrl_chk #(
   .NUM_FUNC (NUM_FUNC),
   .VEC_LOG2 (VEC_LOG2),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .app_req    (app_req),
   .app_ack    (app_ack),
   .app_status (app_status),
   .msg_valid  (msg_valid),
   .msg_ready  (msg_ready),
   .msg_addr   (msg_addr),
   .msg_data   (msg_data),
   .mask_flat  (mask_flat),
   .pend_flat  (pend_flat)
);

// File: tb/tb_msi_pend_ctrl.sv
module tb_msi_pend_ctrl;

   localparam int NUM_FUNC = 4;
   localparam int VEC_LOG2 = 5;
   localparam int ADDR_W   = 64;
   localparam int FUNC_W   = 2;

   localparam logic [2:0] S_CTRL = 3'd0, S_ALO = 3'd1, S_AHI = 3'd2,
                          S_DATA = 3'd3, S_MASK = 3'd4, S_PEND = 3'd5;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                cfg_wr = 1'b0;
   logic [FUNC_W-1:0]   cfg_func = '0;
   logic [2:0]          cfg_sel = '0;
   logic [31:0]         cfg_wdata = '0;
   logic [31:0]         cfg_rdata;
   logic                app_req = 1'b0;
   logic                app_drop = 1'b0;
   logic [FUNC_W-1:0]   app_func = '0;
   logic [VEC_LOG2-1:0] app_vec = '0;
   logic                app_ack;
   logic [1:0]          app_status;
   logic                msg_valid;
   logic                msg_ready = 1'b1;
   logic [ADDR_W-1:0]   msg_addr;
   logic [31:0]         msg_data;

   int n_chk = 0;
   int n_bad = 0;
   int msg_cnt = 0;
   logic [63:0] log_addr [64];
   logic [31:0] log_data [64];

   always #4 clk = ~clk;

   msi_pend_ctrl #(
      .NUM_FUNC (NUM_FUNC),
      .VEC_LOG2 (VEC_LOG2),
      .ADDR_W   (ADDR_W)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_func   (cfg_func),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .app_req    (app_req),
      .app_drop   (app_drop),
      .app_func   (app_func),
      .app_vec    (app_vec),
      .app_ack    (app_ack),
      .app_status (app_status),
      .msg_valid  (msg_valid),
      .msg_ready  (msg_ready),
      .msg_addr   (msg_addr),
      .msg_data   (msg_data)
   );

   // record every message transfer (valid and ready before the next rising edge)
   always @(negedge clk) begin
      #1;
      if (rst_n && msg_valid && msg_ready) begin
         if (msg_cnt < 64) begin
            log_addr[msg_cnt] = msg_addr;
            log_data[msg_cnt] = msg_data;
         end
         msg_cnt++;
      end
   end

   task automatic check_eq(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input int f, input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_func = FUNC_W'(f); cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic cfg_read(input int f, input logic [2:0] s, output logic [31:0] d);
      @(negedge clk);
      cfg_func = FUNC_W'(f); cfg_sel = s;
      #1 d = cfg_rdata;
   endtask

   task automatic app_call(input int f, input int v, input logic drop,
                           output logic [1:0] st);
      @(negedge clk);
      app_req = 1'b1; app_func = FUNC_W'(f); app_vec = VEC_LOG2'(v); app_drop = drop;
      @(negedge clk);
      check_eq("R11", "ack in cycle after sampling", 64'(app_ack), 64'd1);
      st = app_status;
      app_req = 1'b0; app_drop = 1'b0;
      @(negedge clk);
      check_eq("R11", "ack lasts one cycle", 64'(app_ack), 64'd0);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check_eq("R1", "ack after reset", 64'(app_ack), 64'd0);
      check_eq("R1", "msg_valid after reset", 64'(msg_valid), 64'd0);
      cfg_read(0, S_CTRL, d);
      check_eq("R1", "control after reset", 64'(d), 64'd0);
      cfg_read(2, S_MASK, d);
      check_eq("R1", "mask after reset", 64'(d), 64'd0);
   endtask

   task automatic t_setup();
      logic [31:0] d;
      cfg_write(0, S_CTRL, 32'h0000_0105);
      cfg_write(0, S_ALO, 32'hFEE0_0000);
      cfg_write(0, S_AHI, 32'h0000_0001);
      cfg_write(0, S_DATA, 32'hABCD_1234);
      cfg_read(0, S_CTRL, d);
      check_eq("R2", "control readback", 64'(d), 64'h105);
      cfg_read(0, S_AHI, d);
      check_eq("R2", "address high readback", 64'(d), 64'h1);
      cfg_read(0, S_DATA, d);
      check_eq("R2", "data readback", 64'(d), 64'hABCD_1234);
   endtask

   task automatic t_sent();
      logic [1:0] st;
      int base;
      base = msg_cnt;
      app_call(0, 2, 1'b0, st);
      check_eq("R3", "status open vector", 64'(st), 64'h0);
      idle(3);
      check_eq("R3", "one message", 64'(msg_cnt - base), 64'd1);
      check_eq("R3", "message address", log_addr[base], 64'h0000_0001_FEE0_0000);
      check_eq("R4", "data low bits = vector", 64'(log_data[base]), 64'hABCD_1236);
   endtask

   task automatic t_reject();
      logic [1:0] st;
      logic [31:0] d;
      int base;
      base = msg_cnt;
      app_call(0, 4, 1'b0, st);
      check_eq("R5", "status vector out of range", 64'(st), 64'h2);
      app_call(1, 0, 1'b0, st);
      check_eq("R5", "status function disabled", 64'(st), 64'h2);
      idle(3);
      check_eq("R5", "no message", 64'(msg_cnt - base), 64'd0);
      cfg_read(0, S_PEND, d);
      check_eq("R5", "no pending", 64'(d), 64'd0);
   endtask

   task automatic t_masked_unmask();
      logic [1:0] st;
      logic [31:0] d;
      int base;
      base = msg_cnt;
      cfg_write(0, S_MASK, 32'h2);
      app_call(0, 1, 1'b0, st);
      check_eq("R6", "status masked", 64'(st), 64'h1);
      idle(3);
      check_eq("R6", "no message while masked", 64'(msg_cnt - base), 64'd0);
      cfg_read(0, S_PEND, d);
      check_eq("R6", "pending bit set", 64'(d), 64'h2);
      cfg_write(0, S_PEND, 32'h0);
      cfg_read(0, S_PEND, d);
      check_eq("R6", "pending write ignored", 64'(d), 64'h2);
      cfg_write(0, S_MASK, 32'h0);
      cfg_read(0, S_PEND, d);
      check_eq("R7", "pending cleared on unmask", 64'(d), 64'h0);
      idle(4);
      check_eq("R7", "deferred message sent", 64'(msg_cnt - base), 64'd1);
      check_eq("R7", "deferred message data", 64'(log_data[base]), 64'hABCD_1235);
   endtask

   task automatic t_drop();
      logic [1:0] st;
      logic [31:0] d;
      int base;
      base = msg_cnt;
      cfg_write(0, S_MASK, 32'h8);
      app_call(0, 3, 1'b0, st);
      check_eq("R6", "status masked v3", 64'(st), 64'h1);
      app_call(0, 3, 1'b1, st);
      check_eq("R8", "status dropped", 64'(st), 64'h3);
      cfg_read(0, S_PEND, d);
      check_eq("R8", "pending cleared by drop", 64'(d), 64'h0);
      cfg_write(0, S_MASK, 32'h0);
      idle(4);
      check_eq("R8", "no message after unmask", 64'(msg_cnt - base), 64'd0);
   endtask

   task automatic t_order_hold();
      logic [1:0] st;
      logic [31:0] held;
      int base;
      cfg_write(1, S_CTRL, 32'h0000_000F);
      cfg_write(1, S_ALO, 32'h0000_1000);
      cfg_write(1, S_DATA, 32'hFFFF_FFFF);
      cfg_write(0, S_MASK, 32'hB);
      cfg_write(1, S_MASK, 32'h400);
      app_call(0, 3, 1'b0, st);
      app_call(0, 1, 1'b0, st);
      app_call(0, 0, 1'b0, st);
      app_call(1, 10, 1'b0, st);
      check_eq("R4", "code 7 allows vector 10", 64'(st), 64'h1);
      base = msg_cnt;
      @(negedge clk);
      msg_ready = 1'b0;
      cfg_write(0, S_MASK, 32'h0);
      cfg_write(1, S_MASK, 32'h0);
      idle(1);
      held = msg_data;
      idle(3);
      check_eq("R12", "valid held while not ready", 64'(msg_valid), 64'd1);
      check_eq("R12", "data held while not ready", 64'(msg_data), 64'(held));
      msg_ready = 1'b1;
      idle(8);
      check_eq("R9", "four deferred messages", 64'(msg_cnt - base), 64'd4);
      check_eq("R9", "first is f0 v0", 64'(log_data[base]), 64'hABCD_1234);
      check_eq("R9", "second is f0 v1", 64'(log_data[base+1]), 64'hABCD_1235);
      check_eq("R9", "third is f0 v3", 64'(log_data[base+2]), 64'hABCD_1237);
      check_eq("R4", "f1 data with code clamped to 5", 64'(log_data[base+3]), 64'hFFFF_FFEA);
      check_eq("R9", "fourth address is f1", log_addr[base+3], 64'h0000_0000_0000_1000);
   endtask

   task automatic t_same_cycle();
      logic [1:0] st;
      logic [31:0] d;
      int base;
      cfg_write(0, S_MASK, 32'h4);
      app_call(0, 2, 1'b0, st);
      check_eq("R6", "status masked v2", 64'(st), 64'h1);
      base = msg_cnt;
      @(negedge clk);
      cfg_wr = 1'b1; cfg_func = '0; cfg_sel = S_MASK; cfg_wdata = 32'h0;
      app_req = 1'b1; app_func = '0; app_vec = 5'd2; app_drop = 1'b0;
      @(negedge clk);
      cfg_wr = 1'b0; app_req = 1'b0;
      check_eq("R10", "ack with unmask", 64'(app_ack), 64'd1);
      check_eq("R10", "status under new mask", 64'(app_status), 64'h0);
      idle(4);
      check_eq("R10", "single combined message", 64'(msg_cnt - base), 64'd1);
      check_eq("R10", "combined message data", 64'(log_data[base]), 64'hABCD_1236);
      cfg_read(0, S_PEND, d);
      check_eq("R10", "pending clear", 64'(d), 64'h0);
   endtask

   task automatic t_cadence();
      logic [3:0] pat;
      int base;
      base = msg_cnt;
      @(negedge clk);
      app_req = 1'b1; app_func = '0; app_vec = '0; app_drop = 1'b0;
      for (int i = 3; i >= 0; i--) begin
         @(negedge clk);
         pat[i] = app_ack;
      end
      app_req = 1'b0;
      check_eq("R11", "held request ack pattern", 64'(pat), 64'hA);
      idle(5);
      check_eq("R11", "two messages for two acks", 64'(msg_cnt - base), 64'd2);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_setup();
      t_sent();
      t_reject();
      t_masked_unmask();
      t_drop();
      t_order_hold();
      t_same_cycle();
      t_cadence();
      idle(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule